// File: doc/BRIEF.md
# APB Debug Region Decoder

This block is the slave-side front end of a debug APB port. It takes the word address of each transfer (byte address bits 16 down to 2), picks one of a fixed set of debug sub-regions from the top five bits of that word address, and sends the transfer to that region. The regions are a ROM table, a debug register bank and a performance-monitor bank for each of two cores, a cross-trigger unit for each core and two trace units. Inside each region only a small stub register file is modelled. The stub keeps written words so that routing can be seen from the bus.

Two parameters state whether the second core and the second trace unit exist. The regions of a missing unit behave as reserved space. A separate input enables writes from software. When that input is low, only transfers that carry the external-debugger flag may change a register. Every transfer takes one wait state. It ends with read data, a ready and a slave-error flag.

Top module: `dbg_apb_decoder`

## Requirements
- R1: Word-address bits [14:10] give the region code. 00000 selects the ROM table, 10000 core 0 debug, 10001 core 0 monitor, 10010 core 1 debug, 10011 core 1 monitor, 11000 cross-trigger 0, 11001 cross-trigger 1, 11100 trace 0 and 11101 trace 1. Each region holds its own storage, so a write to one region is read back only from that region.
- R2: With `HAS_CORE1`=0, codes 10010, 10011 and 11001 are reserved. A transfer to them ends with `pslverr`=1 and `prdata`=0 and writes nothing.
- R3: With `HAS_TRACE1`=0, code 11101 is reserved and behaves as in R2.
- R4: Every code not listed in R1 ends with `pslverr`=1 and `prdata`=0 and writes nothing.
- R5: Each transfer takes one wait state. `pready` is 0 in the first access cycle (`psel`=1, `penable`=1) and 1 in the second. `pready`, `pslverr` and `prdata` are 0 outside a completing cycle.
- R6: When `sw_en`=0 and `pext`=0, a write ends with `pslverr`=1 and leaves the target word unchanged.
- R7: A write with `pext`=1 succeeds whatever the value of `sw_en`. With `sw_en`=1, a write with `pext`=0 also succeeds.
- R8: Reads succeed with any `pext`/`sw_en` combination and return the stored word with `pslverr`=0.
- R9: After reset, every stub word reads as 0.
- R10: Word-address bits [1:0] select one of 4 words in a region. If any of bits [9:2] is non-zero, the transfer ends with an error and writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Selects this slave |
| penable | input | 1 | High in the access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 15 | Word address (byte address bits 16:2) |
| pext | input | 1 | 1 = access from the external debugger |
| pwdata | input | 32 | Write data |
| sw_en | input | 1 | 1 = writes from software are permitted |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer completes |
| pslverr | output | 1 | Transfer failed |

## Verification
A locked write and a reserved region can both apply to the same transfer. For example, a write with `pext`=0 and `sw_en`=0 to code 11001 on the instance without core 1 meets both conditions. Both must raise one error and must not write. The bench runs the same bus into two instances, one with every unit present and one with the optional units absent. It sends such combined transfers to both and then reads the neighbouring present regions to confirm that nothing was written. A second overlap is the wait state and the completion. Each transfer is sampled in its first and its second access cycle, and the error must appear only together with `pready`.

// File: rtl/dbg_dec_pkg.sv
package dbg_dec_pkg;

    localparam int RCODE_W = 5;
    localparam int NUM_RGN = 9;

    typedef enum logic [3:0] {
        RG_ROM  = 4'd0,
        RG_DBG0 = 4'd1,
        RG_MON0 = 4'd2,
        RG_DBG1 = 4'd3,
        RG_MON1 = 4'd4,
        RG_XT0  = 4'd5,
        RG_XT1  = 4'd6,
        RG_TR0  = 4'd7,
        RG_TR1  = 4'd8,
        RG_NONE = 4'd15
    } rgn_e;

    typedef struct packed {
        logic hit;
        rgn_e id;
    } rgn_sel_t;

    typedef struct packed {
        logic complete;
        logic err;
        logic wr_ok;
    } xfer_res_t;

    // Maps a five-bit region code to a region, taking the presence of optional units into account.
    function automatic rgn_sel_t map_code(input logic [RCODE_W-1:0] code,
                                          input logic core1, input logic trace1);
        rgn_sel_t s;
        s.hit = 1'b1;
        s.id  = RG_NONE;
        unique case (code)
            5'b00000: s.id = RG_ROM;
            5'b10000: s.id = RG_DBG0;
            5'b10001: s.id = RG_MON0;
            5'b10010: s.id = core1  ? RG_DBG1 : RG_NONE;
            5'b10011: s.id = core1  ? RG_MON1 : RG_NONE;
            5'b11000: s.id = RG_XT0;
            5'b11001: s.id = core1  ? RG_XT1  : RG_NONE;
            5'b11100: s.id = RG_TR0;
            5'b11101: s.id = trace1 ? RG_TR1  : RG_NONE;
            default:  s.id = RG_NONE;
        endcase
        if (s.id == RG_NONE) s.hit = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/dbg_region_map.sv
module dbg_region_map
    import dbg_dec_pkg::*;
#(
    parameter int  ADDR_W     = 15,
    parameter int  IDX_W      = 2,
    parameter bit  HAS_CORE1  = 1'b1,
    parameter bit  HAS_TRACE1 = 1'b1
) (
    input  logic [ADDR_W-1:0]  addr,
    output rgn_sel_t           sel,
    output logic [NUM_RGN-1:0] sel_vec,
    output logic               in_range,
    output logic [IDX_W-1:0]   idx
);
    localparam int MID_HI = ADDR_W - RCODE_W - 1;

    logic [RCODE_W-1:0] code;

    assign code     = addr[ADDR_W-1 -: RCODE_W];
    assign sel      = map_code(code, HAS_CORE1, HAS_TRACE1);
    assign idx      = addr[IDX_W-1:0];
    assign in_range = (addr[MID_HI:IDX_W] == '0);

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_sel
        assign sel_vec[g] = sel.hit && (sel.id == rgn_e'(g));
    end
endmodule

// File: rtl/dbg_xfer_ctrl.sv
module dbg_xfer_ctrl
    import dbg_dec_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      psel,
    input  logic      penable,
    input  logic      pwrite,
    input  logic      pext,
    input  logic      sw_en,
    input  logic      rgn_hit,
    input  logic      in_range,
    output xfer_res_t res
);
    logic access;
    logic waited;
    logic locked;

    assign access = psel && penable;
    assign locked = pwrite && !pext && !sw_en;

    // The first access cycle only sets the flag; the transfer completes in the second.
    always_ff @(posedge clk) begin
        if (rst) begin
            waited <= 1'b0;
        end else if (!access) begin
            waited <= 1'b0;
        end else begin
            waited <= !waited;
        end
    end

    always_comb begin
        res.complete = access && waited;
        res.err      = res.complete && (!rgn_hit || !in_range || locked);
        res.wr_ok    = res.complete && pwrite && !res.err;
    end
endmodule

// File: rtl/dbg_stub_regs.sv
module dbg_stub_regs #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/dbg_apb_decoder.sv
module dbg_apb_decoder
    import dbg_dec_pkg::*;
#(
    parameter bit HAS_CORE1  = 1'b1,
    parameter bit HAS_TRACE1 = 1'b1,
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 32,
    parameter int RGN_DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic              pext,
    input  logic [DATA_W-1:0] pwdata,
    input  logic              sw_en,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr
);
    localparam int IDX_W = $clog2(RGN_DEPTH);

    rgn_sel_t           sel;
    logic [NUM_RGN-1:0] sel_vec;
    logic [NUM_RGN-1:0] wr_stb;
    logic               in_range;
    logic [IDX_W-1:0]   idx;
    xfer_res_t          res;
    logic [DATA_W-1:0]  rd_arr [NUM_RGN];
    logic [DATA_W-1:0]  rd_sel;

    dbg_region_map #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W),
        .HAS_CORE1(HAS_CORE1), .HAS_TRACE1(HAS_TRACE1)
    ) u_map (
        .addr(paddr), .sel(sel), .sel_vec(sel_vec),
        .in_range(in_range), .idx(idx)
    );

    dbg_xfer_ctrl u_ctrl (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable),
        .pwrite(pwrite), .pext(pext), .sw_en(sw_en),
        .rgn_hit(sel.hit), .in_range(in_range), .res(res)
    );

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
        assign wr_stb[g] = res.wr_ok && sel_vec[g];
        dbg_stub_regs #(.DEPTH(RGN_DEPTH), .DATA_W(DATA_W)) u_stub (
            .clk(clk), .rst(rst), .we(wr_stb[g]), .idx(idx),
            .wdata(pwdata), .rdata(rd_arr[g])
        );
    end

    always_comb begin
        rd_sel = '0;
        for (int i = 0; i < NUM_RGN; i++) begin
            if (sel_vec[i]) rd_sel = rd_arr[i];
        end
    end

    assign pready  = res.complete;
    assign pslverr = res.err;
    assign prdata  = (res.complete && !res.err && !pwrite) ? rd_sel : '0;
endmodule

// File: rtl/dbg_apb_decoder_chk.sv
module dbg_apb_decoder_chk
    import dbg_dec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic              pext,
    input logic              sw_en,
    input logic              pready,
    input logic              pslverr,
    input logic [DATA_W-1:0] prdata,
    input logic [NUM_RGN-1:0] wr_stb
);
    // R5: ready only in an access phase
    p_ready_in_access_r5: assert property (@(posedge clk) disable iff (rst)
        pready |-> (psel && penable));

    // R5: the first access cycle after a setup cycle is always a wait
    p_first_wait_r5: assert property (@(posedge clk) disable iff (rst)
        (psel && !penable) ##1 (psel && penable) |-> !pready);

    // R5: error is flagged only with ready
    p_err_with_ready_r5: assert property (@(posedge clk) disable iff (rst)
        pslverr |-> pready);

    // R4: a failed transfer returns zero data
    p_err_zero_data_r4: assert property (@(posedge clk) disable iff (rst)
        pslverr |-> (prdata == '0));

    // R6: a locked write always fails
    p_lock_err_r6: assert property (@(posedge clk) disable iff (rst)
        (pready && pwrite && !pext && !sw_en) |-> pslverr);

    // R1: at most one region written, and never in a failed transfer
    p_one_target_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_stb));
    p_no_write_on_err_r2: assert property (@(posedge clk) disable iff (rst)
        pslverr |-> (wr_stb == '0));
endmodule

bind dbg_apb_decoder dbg_apb_decoder_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .pext(pext), .sw_en(sw_en), .pready(pready), .pslverr(pslverr),
    .prdata(prdata), .wr_stb(wr_stb)
);

// File: tb/sim_dbg_apb_decoder.sv
module sim_dbg_apb_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, pext = 1'b0, sw_en = 1'b1;
    logic [14:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] rd0, rd1;
    logic        rdy0, rdy1, err0, err1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // u0: every unit present; u1: second core and second trace unit absent
    dbg_apb_decoder #(.HAS_CORE1(1'b1), .HAS_TRACE1(1'b1)) u0 (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pext(pext), .pwdata(pwdata), .sw_en(sw_en),
        .prdata(rd0), .pready(rdy0), .pslverr(err0));
    dbg_apb_decoder #(.HAS_CORE1(1'b0), .HAS_TRACE1(1'b0)) u1 (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pext(pext), .pwdata(pwdata), .sw_en(sw_en),
        .prdata(rd1), .pready(rdy1), .pslverr(err1));

    localparam logic [4:0] CODES [9] = '{5'b00000, 5'b10000, 5'b10001, 5'b10010,
                                         5'b10011, 5'b11000, 5'b11001, 5'b11100, 5'b11101};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit absent1(input logic [4:0] c);
        return (c == 5'b10010) || (c == 5'b10011) || (c == 5'b11001) || (c == 5'b11101);
    endfunction

    // One APB transfer on both instances; checks the wait state (R5)
    task automatic xfer(input logic wr, input logic ext, input logic [4:0] code,
                        input logic [9:0] low, input logic [31:0] wd,
                        output logic [31:0] r0, output logic e0,
                        output logic [31:0] r1, output logic e1);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; pext = ext;
        paddr = {code, low}; pwdata = wd;
        @(negedge clk);
        penable = 1'b1;
        #1;
        chk(!rdy0 && !rdy1, "R5 first access cycle not ready", {30'b0, rdy0, rdy1}, 32'h0);
        @(negedge clk);
        chk(rdy0 && rdy1, "R5 second access cycle ready", {30'b0, rdy0, rdy1}, 32'h3);
        r0 = rd0; e0 = err0; r1 = rd1; e1 = err1;
        @(posedge clk);
        #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        #1;
        chk(!rdy0 && !err0 && rd0 == 0, "R5 idle outputs zero", rd0, 32'h0);
    endtask

    task automatic t_reset;
        logic [31:0] r0, r1; logic e0, e1;
        chk(!rdy0 && !err0 && rd0 == 0, "R9 outputs after reset", rd0, 32'h0);
        for (int k = 0; k < 9; k++) begin
            xfer(1'b0, 1'b1, CODES[k], 10'd2, 32'h0, r0, e0, r1, e1);
            chk(!e0 && r0 == 0, "R9 reset word zero", r0, 32'h0);
        end
    endtask

    task automatic t_regions;
        logic [31:0] r0, r1; logic e0, e1;
        for (int k = 0; k < 9; k++)
            xfer(1'b1, 1'b1, CODES[k], 10'd1, 32'hA500_0000 | k, r0, e0, r1, e1);
        for (int k = 0; k < 9; k++) begin
            xfer(1'b0, 1'b1, CODES[k], 10'd1, 32'h0, r0, e0, r1, e1);
            chk(!e0 && r0 == (32'hA500_0000 | k), "R1 region readback full", r0, 32'hA500_0000 | k);
            if (CODES[k] == 5'b11101) begin
                chk(e1 && r1 == 0, "R3 trace1 reserved", r1, 32'h0);
            end else if (absent1(CODES[k])) begin
                chk(e1 && r1 == 0, "R2 core1 region reserved", r1, 32'h0);
            end else begin
                chk(!e1 && r1 == (32'hA500_0000 | k), "R1 region readback reduced", r1, 32'hA500_0000 | k);
            end
        end
    endtask

    task automatic t_unlisted;
        logic [31:0] r0, r1; logic e0, e1;
        logic [4:0] bad [4] = '{5'b00001, 5'b01000, 5'b10100, 5'b11111};
        for (int k = 0; k < 4; k++) begin
            xfer(1'b1, 1'b1, bad[k], 10'd1, 32'hDEAD_BEEF, r0, e0, r1, e1);
            chk(e0 && e1, "R4 unlisted write error", {31'b0, e0}, 32'h1);
            xfer(1'b0, 1'b1, bad[k], 10'd1, 32'h0, r0, e0, r1, e1);
            chk(e0 && r0 == 0 && r1 == 0, "R4 unlisted read zero", r0, 32'h0);
        end
        xfer(1'b0, 1'b1, 5'b10000, 10'd1, 32'h0, r0, e0, r1, e1);
        chk(r0 == 32'hA500_0001, "R4 no side effect", r0, 32'hA500_0001);
    endtask

    task automatic t_index;
        logic [31:0] r0, r1; logic e0, e1;
        xfer(1'b1, 1'b1, 5'b11000, 10'd0, 32'h1111_0000, r0, e0, r1, e1);
        xfer(1'b1, 1'b1, 5'b11000, 10'd3, 32'h3333_0003, r0, e0, r1, e1);
        xfer(1'b0, 1'b1, 5'b11000, 10'd0, 32'h0, r0, e0, r1, e1);
        chk(r0 == 32'h1111_0000, "R10 word 0", r0, 32'h1111_0000);
        xfer(1'b0, 1'b1, 5'b11000, 10'd3, 32'h0, r0, e0, r1, e1);
        chk(r0 == 32'h3333_0003, "R10 word 3", r0, 32'h3333_0003);
        xfer(1'b1, 1'b1, 5'b11000, 10'h103, 32'hFFFF_FFFF, r0, e0, r1, e1);
        chk(e0, "R10 out-of-range error", {31'b0, e0}, 32'h1);
        xfer(1'b0, 1'b1, 5'b11000, 10'd3, 32'h0, r0, e0, r1, e1);
        chk(r0 == 32'h3333_0003, "R10 out-of-range no write", r0, 32'h3333_0003);
    endtask

    task automatic t_lockout;
        logic [31:0] r0, r1; logic e0, e1;
        sw_en = 1'b0;
        xfer(1'b1, 1'b0, 5'b10001, 10'd1, 32'h0BAD_0000, r0, e0, r1, e1);
        chk(e0 && e1, "R6 locked write error", {31'b0, e0}, 32'h1);
        xfer(1'b0, 1'b0, 5'b10001, 10'd1, 32'h0, r0, e0, r1, e1);
        chk(!e0 && r0 == 32'hA500_0002, "R8 read under lockout", r0, 32'hA500_0002);
        chk(r1 == 32'hA500_0002, "R6 word unchanged", r1, 32'hA500_0002);
        // lock and reserved together on the reduced instance
        xfer(1'b1, 1'b0, 5'b11001, 10'd1, 32'h0BAD_0001, r0, e0, r1, e1);
        chk(e0 && e1, "R6 locked write to reserved", {30'b0, e0, e1}, 32'h3);
        xfer(1'b0, 1'b1, 5'b11001, 10'd1, 32'h0, r0, e0, r1, e1);
        chk(r0 == 32'hA500_0006 && e1 && r1 == 0, "R2 combined no write", r0, 32'hA500_0006);
        xfer(1'b1, 1'b1, 5'b10001, 10'd1, 32'h5A5A_0001, r0, e0, r1, e1);
        chk(!e0 && !e1, "R7 external write with lock", {30'b0, e0, e1}, 32'h0);
        xfer(1'b0, 1'b0, 5'b10001, 10'd1, 32'h0, r0, e0, r1, e1);
        chk(r0 == 32'h5A5A_0001 && r1 == 32'h5A5A_0001, "R7 external write stored", r0, 32'h5A5A_0001);
        sw_en = 1'b1;
        xfer(1'b1, 1'b0, 5'b10001, 10'd1, 32'h6B6B_0002, r0, e0, r1, e1);
        chk(!e0, "R7 software write enabled", {31'b0, e0}, 32'h0);
        xfer(1'b0, 1'b0, 5'b10001, 10'd1, 32'h0, r0, e0, r1, e1);
        chk(r0 == 32'h6B6B_0002 && !e0, "R8 read with software enabled", r0, 32'h6B6B_0002);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_regions();
        t_unlisted();
        t_index();
        t_lockout();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule